// File: doc/BRIEF.md
# Tiled Multi-Input Bit-Vector Dot-Product Array

This block computes the binary dot product (the number of positions where both vectors hold a 1) between every pair formed from a set of input bit vectors and a set of reference bit vectors. The vectors are long, so they are processed in fixed-width slices. For each slice position, the matching slice of every reference vector is written into on-chip registers. The matching slice of every input vector is then streamed past those registers. Each input slice updates one row of running counts, one count per reference, through parallel AND-popcount units. Each loaded reference slice is therefore reused against all inputs, which cuts the memory traffic needed per partial product.

A job begins with `start`. The controller moves through four states. IDLE goes to LOAD when `start` is accepted. LOAD goes to STREAM after the last reference slice of the current position. STREAM goes back to LOAD after the last input slice if slice positions remain. STREAM goes to READOUT after the last input slice of the last position. READOUT returns to IDLE after the final count. In READOUT the whole count array is emitted, one count per cycle.

Top module: `bitdot_tile_array`

## Requirements
- R1: While reset is held and right after it, `ref_ready`, `in_ready`, `res_valid` and `done` are all 0 (state IDLE).
- R2: A `start` accepted in IDLE clears every count to zero and opens LOAD: `ref_ready` is 1 in the next cycle, and the slice position restarts at 0.
- R3: In LOAD, each cycle with `ref_valid` high stores `ref_data` as the current slice of the next reference, in index order 0..NREF-1. After NREF stores the block enters STREAM and `in_ready` is 1.
- R4: In STREAM, each cycle with `in_valid` high takes `in_data` as the current slice of the next input vector, in order 0..NIN-1. For every reference j, in that same cycle, it adds popcount(`in_data` AND reference slice j) to count[i][j].
- R5: After NIN accepted input slices, the block goes back to LOAD for the next slice position if one remains. After the last position it enters READOUT.
- R6: READOUT holds `res_valid` high for exactly NIN*NREF consecutive cycles. It delivers count[i][j] with `res_idx` = i*NREF + j in ascending order, so input index is major and reference index is minor. `res_last` is high only on the final item, and the block then returns to IDLE.
- R7: `done` rises in the first READOUT cycle and stays high until the next accepted `start`, which drops it in the following cycle.
- R8: Counts are $clog2(SLICE_W*NSLICES)+1 bits wide. Two all-ones vectors give the exact full length (256 with the defaults) and do not wrap.
- R9: `ref_valid` is ignored outside LOAD, `in_valid` is ignored outside STREAM, and `start` is ignored outside IDLE.
- R10: Counts left over from a previous job never leak into the next job's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job (accepted in IDLE only) |
| ref_valid | input | 1 | Reference slice present on `ref_data` |
| ref_data | input | SLICE_W | Reference slice |
| ref_ready | output | 1 | Block is in LOAD |
| in_valid | input | 1 | Input slice present on `in_data` |
| in_data | input | SLICE_W | Input vector slice |
| in_ready | output | 1 | Block is in STREAM |
| res_valid | output | 1 | Count valid on `res_data` |
| res_data | output | CW | Count for pair `res_idx` |
| res_idx | output | IW | Flat pair index i*NREF + j |
| res_last | output | 1 | Final count of the readout |
| done | output | 1 | Job finished; held until the next start |

## Verification
The bench checks the transitions from LOAD to STREAM and from STREAM back to LOAD. An off-by-one pointer there would mix one vector's slices into another's counts, and every pair would miscompare.

It runs an all-ones job to expose a count width too narrow to hold the full length, which would wrap to a small value. It then runs a zero-reference job, which catches counts that are not cleared on start.

It also drives stray `ref_valid`, `in_valid` and `start` in the wrong states. A design that honoured them would overwrite references, add junk slices or wipe counts in the middle of a job.

// File: rtl/bitdot_pkg.sv
package bitdot_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STREAM,
        ST_READOUT
    } state_t;
endpackage

// File: rtl/bitdot_pop_unit.sv
// One AND-popcount lane: ones in (a AND b).
module bitdot_pop_unit #(
    parameter int SLICE_W = 32,
    localparam int PW = $clog2(SLICE_W + 1)
) (
    input  logic [SLICE_W-1:0] a,
    input  logic [SLICE_W-1:0] b,
    output logic [PW-1:0]      ones
);
    always_comb begin
        ones = '0;
        for (int k = 0; k < SLICE_W; k++) begin
            ones = ones + PW'(a[k] & b[k]);
        end
    end
endmodule

// File: rtl/bitdot_ref_bank.sv
// Holds the current slice of every reference vector.
module bitdot_ref_bank #(
    parameter int NREF    = 4,
    parameter int SLICE_W = 32,
    localparam int RW = (NREF > 1) ? $clog2(NREF) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [RW-1:0]                    sel,
    input  logic [SLICE_W-1:0]               wdata,
    output logic [NREF-1:0][SLICE_W-1:0]     slices
);
    for (genvar j = 0; j < NREF; j++) begin : g_ref
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slices[j] <= '0;
            end else if (we && sel == RW'(j)) begin
                slices[j] <= wdata;
            end
        end
    end

    AST_REF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(slices)); // R9
endmodule

// File: rtl/bitdot_ctrl.sv
// Job sequencer: load references, stream inputs, step slices, read out.
module bitdot_ctrl
    import bitdot_pkg::*;
#(
    parameter int NREF    = 4,
    parameter int NIN     = 4,
    parameter int NSLICES = 8,
    localparam int RW = (NREF > 1) ? $clog2(NREF) : 1,
    localparam int MW = (NIN > 1) ? $clog2(NIN) : 1,
    localparam int SW = (NSLICES > 1) ? $clog2(NSLICES) : 1,
    localparam int IW = (NIN * NREF > 1) ? $clog2(NIN * NREF) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ref_valid,
    input  logic          in_valid,
    output logic          ref_ready,
    output logic          in_ready,
    output logic          ref_we,
    output logic [RW-1:0] ref_sel,
    output logic          acc_en,
    output logic [MW-1:0] acc_row,
    output logic          clr,
    output logic          rd_valid,
    output logic [IW-1:0] rd_idx,
    output logic          rd_last,
    output logic          done
);
    state_t state, nxt;
    logic [RW-1:0] ref_ptr;
    logic [MW-1:0] in_ptr;
    logic [SW-1:0] sl_ptr;
    logic [IW-1:0] rd_ptr;
    logic          done_q;
    logic          ref_end, in_end, sl_end, rd_end;

    assign ref_end = (ref_ptr == RW'(NREF - 1));
    assign in_end  = (in_ptr  == MW'(NIN - 1));
    assign sl_end  = (sl_ptr  == SW'(NSLICES - 1));
    assign rd_end  = (rd_ptr  == IW'(NIN * NREF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_LOAD;
            ST_LOAD:    if (ref_valid && ref_end) nxt = ST_STREAM;
            ST_STREAM:  if (in_valid && in_end) nxt = sl_end ? ST_READOUT : ST_LOAD;
            ST_READOUT: if (rd_end) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_ptr <= '0;
            in_ptr  <= '0;
            sl_ptr  <= '0;
            rd_ptr  <= '0;
            done_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    ref_ptr <= '0;
                    in_ptr  <= '0;
                    sl_ptr  <= '0;
                    rd_ptr  <= '0;
                    done_q  <= 1'b0;
                end
                ST_LOAD: if (ref_valid) ref_ptr <= ref_end ? '0 : ref_ptr + 1'b1;
                ST_STREAM: if (in_valid) begin
                    in_ptr <= in_end ? '0 : in_ptr + 1'b1;
                    if (in_end) begin
                        if (sl_end) done_q <= 1'b1;
                        else        sl_ptr <= sl_ptr + 1'b1;
                    end
                end
                ST_READOUT: rd_ptr <= rd_end ? '0 : rd_ptr + 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        ref_ready = (state == ST_LOAD);
        in_ready  = (state == ST_STREAM);
        rd_valid  = (state == ST_READOUT);
        clr       = (state == ST_IDLE) && start;
        ref_we    = ref_ready && ref_valid;
        ref_sel   = ref_ptr;
        acc_en    = in_ready && in_valid;
        acc_row   = in_ptr;
        rd_idx    = rd_ptr;
        rd_last   = rd_valid && rd_end;
        done      = done_q;
    end

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ref_ready, in_ready, rd_valid})); // R5
    AST_LOAD_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ref_ready); // R2
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done); // R7
    AST_BURST_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_last) |=> rd_valid); // R6
    AST_BURST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |=> !rd_valid); // R6
endmodule

// File: rtl/bitdot_tile_array.sv
// Top: reference slice bank, NREF popcount lanes, NIN x NREF count array.
module bitdot_tile_array #(
    parameter int NREF    = 4,
    parameter int NIN     = 4,
    parameter int SLICE_W = 32,
    parameter int NSLICES = 8,
    localparam int CW   = $clog2(SLICE_W * NSLICES) + 1,
    localparam int IW   = (NIN * NREF > 1) ? $clog2(NIN * NREF) : 1,
    localparam int RW   = (NREF > 1) ? $clog2(NREF) : 1,
    localparam int MW   = (NIN > 1) ? $clog2(NIN) : 1,
    localparam int PW   = $clog2(SLICE_W + 1),
    localparam int MAXC = SLICE_W * NSLICES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               ref_valid,
    input  logic [SLICE_W-1:0] ref_data,
    output logic               ref_ready,
    input  logic               in_valid,
    input  logic [SLICE_W-1:0] in_data,
    output logic               in_ready,
    output logic               res_valid,
    output logic [CW-1:0]      res_data,
    output logic [IW-1:0]      res_idx,
    output logic               res_last,
    output logic               done
);
    logic          ref_we, acc_en, clr;
    logic [RW-1:0] ref_sel;
    logic [MW-1:0] acc_row;
    logic [NREF-1:0][SLICE_W-1:0] slices;
    logic [NREF-1:0][PW-1:0]      pop;
    logic [NIN-1:0][NREF-1:0][CW-1:0] counts;
    logic [CW-1:0] flat [NIN*NREF];

    bitdot_ctrl #(.NREF(NREF), .NIN(NIN), .NSLICES(NSLICES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ref_valid(ref_valid), .in_valid(in_valid),
        .ref_ready(ref_ready), .in_ready(in_ready),
        .ref_we(ref_we), .ref_sel(ref_sel),
        .acc_en(acc_en), .acc_row(acc_row), .clr(clr),
        .rd_valid(res_valid), .rd_idx(res_idx), .rd_last(res_last),
        .done(done)
    );

    bitdot_ref_bank #(.NREF(NREF), .SLICE_W(SLICE_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(ref_we), .sel(ref_sel),
        .wdata(ref_data), .slices(slices)
    );

    for (genvar j = 0; j < NREF; j++) begin : g_lane
        bitdot_pop_unit #(.SLICE_W(SLICE_W)) u_pop (
            .a(in_data), .b(slices[j]), .ones(pop[j])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            counts <= '0;
        end else if (clr) begin
            counts <= '0;
        end else if (acc_en) begin
            for (int i = 0; i < NIN; i++) begin
                if (acc_row == MW'(i)) begin
                    for (int j = 0; j < NREF; j++) begin
                        counts[i][j] <= counts[i][j] + CW'(pop[j]);
                    end
                end
            end
        end
    end

    for (genvar i = 0; i < NIN; i++) begin : g_row
        for (genvar j = 0; j < NREF; j++) begin : g_col
            assign flat[i*NREF + j] = counts[i][j];
            AST_COUNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
                counts[i][j] <= CW'(MAXC)); // R8
        end
    end

    assign res_data = flat[res_idx];

    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (counts == '0)); // R2
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !clr) |=> $stable(counts)); // R9
endmodule

// File: tb/tb_bitdot_tile_array.sv
module tb_bitdot_tile_array;
    localparam int NREF = 4;
    localparam int NIN  = 4;
    localparam int SW   = 32;
    localparam int NS   = 8;
    localparam int CW   = $clog2(SW * NS) + 1;
    localparam int IW   = $clog2(NIN * NREF);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ref_valid = 1'b0;
    logic [SW-1:0] ref_data = '0;
    logic ref_ready;
    logic in_valid = 1'b0;
    logic [SW-1:0] in_data = '0;
    logic in_ready, res_valid, res_last, done;
    logic [CW-1:0] res_data;
    logic [IW-1:0] res_idx;

    bitdot_tile_array #(.NREF(NREF), .NIN(NIN), .SLICE_W(SW), .NSLICES(NS)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ref_valid(ref_valid), .ref_data(ref_data), .ref_ready(ref_ready),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .res_valid(res_valid), .res_data(res_data), .res_idx(res_idx),
        .res_last(res_last), .done(done)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int    exp_val[$];
    int    exp_idx[$];
    string exp_tag[$];
    logic [SW-1:0] rv [NREF][NS];
    logic [SW-1:0] iv [NIN][NS];

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: pop the scoreboard as results appear
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_val.size() == 0) begin
                check(1'b0, "R6 unexpected result", int'(res_data), -1);
            end else begin
                int v, ix;
                string t;
                v  = exp_val.pop_front();
                ix = exp_idx.pop_front();
                t  = exp_tag.pop_front();
                check(int'(res_data) == v, t, int'(res_data), v);
                check(int'(res_idx) == ix, "R6 index order", int'(res_idx), ix);
                check(res_last == (ix == NIN*NREF-1), "R6 last flag", int'(res_last), int'(ix == NIN*NREF-1));
                check(done == 1'b1, "R7 done during readout", int'(done), 1);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic fill(input int mode);
        for (int s = 0; s < NS; s++) begin
            for (int j = 0; j < NREF; j++)
                rv[j][s] = (mode == 1) ? '1 : (mode == 2) ? '0 : SW'($urandom);
            for (int i = 0; i < NIN; i++)
                iv[i][s] = (mode == 1) ? '1 : SW'($urandom);
        end
    endtask

    // Driver: push expected counts, then run one job
    task automatic run_job(input string tag, input bit inject);
        for (int i = 0; i < NIN; i++) begin
            for (int j = 0; j < NREF; j++) begin
                int sum = 0;
                for (int s = 0; s < NS; s++) sum += $countones(iv[i][s] & rv[j][s]);
                exp_val.push_back(sum);
                exp_idx.push_back(i*NREF + j);
                exp_tag.push_back(tag);
            end
        end
        start = 1'b1;
        tick();
        start = 1'b0;
        check(ref_ready == 1'b1, "R2 load opens after start", int'(ref_ready), 1);
        check(done == 1'b0, "R7 done drops after start", int'(done), 0);
        for (int s = 0; s < NS; s++) begin
            for (int j = 0; j < NREF; j++) begin
                ref_valid = 1'b1;
                ref_data  = rv[j][s];
                if (inject) begin
                    in_valid = 1'b1;
                    in_data  = '1;
                end
                tick();
            end
            ref_valid = 1'b0;
            in_valid  = 1'b0;
            check(in_ready == 1'b1, "R3 stream after all refs", int'(in_ready), 1);
            tick();
            for (int i = 0; i < NIN; i++) begin
                in_valid = 1'b1;
                in_data  = iv[i][s];
                if (inject) begin
                    ref_valid = 1'b1;
                    ref_data  = '1;
                    start     = 1'b1;
                end
                tick();
            end
            in_valid  = 1'b0;
            ref_valid = 1'b0;
            start     = 1'b0;
            if (s < NS-1)
                check(ref_ready == 1'b1, "R5 next slice reloads", int'(ref_ready), 1);
            else
                check(res_valid == 1'b1, "R5 readout after last slice", int'(res_valid), 1);
        end
        while (res_valid) tick();
        check(exp_val.size() == 0, "R6 all counts delivered", exp_val.size(), 0);
        check(done == 1'b1, "R7 done held after readout", int'(done), 1);
        check(ref_ready == 1'b0 && in_ready == 1'b0, "R6 back to idle", int'(ref_ready), 0);
    endtask

    initial begin
        repeat (3) tick();
        check(ref_ready == 1'b0 && in_ready == 1'b0, "R1 no ready in reset", int'(ref_ready | in_ready), 0);
        check(res_valid == 1'b0 && done == 1'b0, "R1 no result in reset", int'(res_valid | done), 0);
        rst_n = 1'b1;
        tick();
        check(ref_ready == 1'b0 && res_valid == 1'b0 && done == 1'b0, "R1 idle after reset", int'(ref_ready), 0);
        // R9: stray strobes in IDLE
        ref_valid = 1'b1;
        in_valid  = 1'b1;
        repeat (3) tick();
        ref_valid = 1'b0;
        in_valid  = 1'b0;
        check(ref_ready == 1'b0 && in_ready == 1'b0 && res_valid == 1'b0, "R9 idle ignores strobes", int'(in_ready), 0);

        fill(0); run_job("R4 random pairs", 1'b0);
        fill(1); run_job("R8 full-length ones", 1'b0);
        fill(2); run_job("R10 zero refs after full job", 1'b0);
        fill(0); run_job("R9 stray strobes ignored", 1'b1);
        fill(0); run_job("R4 second random set", 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule